// File: doc/BRIEF.md
# Five-Function Integer ALU

This block is the arithmetic-logic unit of a single-cycle processor datapath. It combines two 32-bit operands under a 3-bit control word and returns a 32-bit result, a flag that is high when that result is zero, and the carry leaving the adder. The control word has two parts. A one-bit subtract enable inverts the second operand and forces the adder carry-in high. A two-bit function select chooses the bitwise AND, the bitwise OR, the adder sum, or a signed less-than indication.

The unit is purely combinational. It has no clock, no reset and no stored state. Its outputs follow the operands and the control word after the propagation delay of one carry chain. Branch-on-equal logic in the datapath uses the zero flag after a subtraction. Effective-address and arithmetic paths use the sum. Compare instructions use the less-than code.

Top module: `int_alu5`

## Requirements
- R1: With subtract enable 0 and select 2'b00, the result is the bitwise AND of A and B.
- R2: With subtract enable 0 and select 2'b01, the result is the bitwise OR of A and B.
- R3: With subtract enable 0 and select 2'b10, the result is A + B modulo 2^32.
- R4: With subtract enable 1 and select 2'b10, the result is A - B modulo 2^32, formed as A + ~B + 1.
- R5: With subtract enable 1 and select 2'b11, result bit 0 is 1 exactly when A < B as signed two's-complement numbers, and result bits 31 to 1 are 0.
- R6: The less-than code of R5 stays correct when A - B overflows, for example A = 0x80000000 with B = 1 gives 1, and A = 0x7FFFFFFF with B = 0xFFFFFFFF gives 0.
- R7: The zero output is 1 exactly when all 32 result bits are 0, under every control code.
- R8: The carry output is bit 32 of A + (B XOR {32{sub}}) + sub. For an add it is the unsigned carry of A + B. For a subtract it is 1 exactly when A >= B unsigned.
- R9: The zero output does not depend on the carry output. An add that wraps to 0 with carry 1 gives zero = 1, and an add with result nonzero and carry 1 gives zero = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand A |
| opnd_b | input | 32 | Second operand B |
| sub_en | input | 1 | Inverts B and sets the adder carry-in |
| fn_sel | input | 2 | 00 AND, 01 OR, 10 sum, 11 less-than |
| result | output | 32 | Selected result |
| zero | output | 1 | High when result is all zeros |
| carry_out | output | 1 | Carry out of the most significant adder bit |

## Verification
The case that is hardest to reach from the ports is a less-than compare whose internal subtraction overflows. Here the sign bit of the difference alone gives the wrong answer. Random operands seldom land there, so the stimulus adds directed pairs at the extremes of the signed range: the most negative against positive values, and the most positive against negative values. The same directed set covers the carry and zero corners. These are an add that wraps exactly to zero, and subtractions of equal operands. Sweeps of walking-one and random operands then exercise every control code.

// File: rtl/int_alu5_pkg.sv
// Package: shared definitions for the five-function ALU.
// Assumes: the function select is two bits wide and decoded as listed here.
package int_alu5_pkg;

    // Function select encoding; the less-than code relies on the adder
    // running a subtraction, so it is used together with sub_en = 1.
    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_SUM  = 2'b10,
        FN_LESS = 2'b11
    } fn_sel_e;

endpackage

// File: rtl/int_alu5_adder.sv
// Module: ripple-carry adder with optional operand inversion.
// Computes A + (B ^ {W{inv}}) + inv and reports the final carry and the
// signed overflow (carry into the MSB XOR carry out of the MSB).
// Assumes: W >= 2.
module int_alu5_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         inv,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    logic [W-1:0] b_eff;
    logic [W:0]   carry;

    // Conditional inversion of B shared with the carry-in.
    assign b_eff    = b ^ {W{inv}};
    assign carry[0] = inv;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            // One full-adder cell of the chain.
            assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
            assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
        end
    endgenerate

    assign cout = carry[W];
    assign ovf  = carry[W] ^ carry[W-1];

endmodule

// File: rtl/int_alu5_logic.sv
// Module: bitwise AND and OR of the raw operands.
// Assumes: nothing beyond equal operand widths.
module int_alu5_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_out,
    output logic [W-1:0] or_out
);

    // Plain bitwise functions, one gate level.
    assign and_out = a & b;
    assign or_out  = a | b;

endmodule

// File: rtl/int_alu5_zero.sv
// Module: all-zero detector built as a balanced OR tree.
// Assumes: W is a power of two.
module int_alu5_zero #(
    parameter int W = 32
) (
    input  logic [W-1:0] vec,
    output logic         is_zero
);

    localparam int LVLS = $clog2(W);

    // Node storage for the tree: level l holds W >> l entries.
    logic [W-1:0] node [0:LVLS];

    assign node[0] = vec;

    genvar l, k;
    generate
        for (l = 0; l < LVLS; l++) begin : g_lvl
            localparam int N = W >> (l + 1);
            for (k = 0; k < N; k++) begin : g_or
                // Pairwise OR of the previous level.
                assign node[l+1][k] = node[l][2*k] | node[l][2*k+1];
            end
            // Unused upper bits of this level are tied low.
            assign node[l+1][W-1:N] = '0;
        end
    endgenerate

    assign is_zero = ~node[LVLS][0];

endmodule

// File: rtl/int_alu5.sv
// Module: five-function integer ALU (top).
// Selects AND, OR, sum or signed less-than of two operands; reports a
// zero flag on the selected result and the adder carry out.
// Assumes: purely combinational use; the less-than code is issued with
// sub_en = 1 so the adder forms A - B.
module int_alu5
    import int_alu5_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              sub_en,
    input  logic [1:0]        fn_sel,
    output logic [DATA_W-1:0] result,
    output logic              zero,
    output logic              carry_out
);

    logic [DATA_W-1:0] and_w;
    logic [DATA_W-1:0] or_w;
    logic [DATA_W-1:0] sum_w;
    logic              ovf_w;
    logic              less_w;
    fn_sel_e           fn;

    assign fn = fn_sel_e'(fn_sel);

    int_alu5_logic #(.W(DATA_W)) u_logic (
        .a       (opnd_a),
        .b       (opnd_b),
        .and_out (and_w),
        .or_out  (or_w)
    );

    int_alu5_adder #(.W(DATA_W)) u_adder (
        .a    (opnd_a),
        .b    (opnd_b),
        .inv  (sub_en),
        .sum  (sum_w),
        .cout (carry_out),
        .ovf  (ovf_w)
    );

    // Signed less-than: difference sign corrected by overflow.
    assign less_w = sum_w[DATA_W-1] ^ ovf_w;

    // Result selection by function code.
    always_comb begin
        unique case (fn)
            FN_AND:  result = and_w;
            FN_OR:   result = or_w;
            FN_SUM:  result = sum_w;
            FN_LESS: result = {{(DATA_W-1){1'b0}}, less_w};
            default: result = sum_w;
        endcase
    end

    int_alu5_zero #(.W(DATA_W)) u_zero (
        .vec     (result),
        .is_zero (zero)
    );

endmodule

// File: rtl/int_alu5_chk.sv
// Module: assertion checker for int_alu5, bound to every instance.
// Assumes: inputs are settled when the combinational process evaluates.
module int_alu5_chk #(
    parameter int DATA_W = 32
) (
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              sub_en,
    input logic [1:0]        fn_sel,
    input logic [DATA_W-1:0] result,
    input logic              zero,
    input logic              carry_out
);

    logic [DATA_W:0] ref_sum;
    logic [DATA_W:0] ref_diff;

    // Reference arithmetic for the checks below.
    assign ref_sum  = {1'b0, opnd_a} + {1'b0, opnd_b};
    assign ref_diff = {1'b0, opnd_a} + {1'b0, ~opnd_b} + 1'b1;

    // Immediate checks of the output against the control code.
    always_comb begin
        if (!sub_en && fn_sel == 2'b00) AST_AND_RESULT: assert (result == (opnd_a & opnd_b)); // R1
        if (!sub_en && fn_sel == 2'b01) AST_OR_RESULT: assert (result == (opnd_a | opnd_b)); // R2
        if (!sub_en && fn_sel == 2'b10) AST_ADD_RESULT: assert ({carry_out, result} == ref_sum); // R3
        if (sub_en && fn_sel == 2'b10) AST_SUB_RESULT: assert ({carry_out, result} == ref_diff); // R4
        if (sub_en && fn_sel == 2'b11) AST_LESS_UPPER: assert (result[DATA_W-1:1] == '0); // R5
        if (sub_en && fn_sel == 2'b11) AST_LESS_SIGNED: assert (result[0] == ($signed(opnd_a) < $signed(opnd_b))); // R6
        AST_ZERO_FLAG: assert (zero == (result == '0)); // R7
    end

endmodule

bind int_alu5 int_alu5_chk #(.DATA_W(DATA_W)) u_int_alu5_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .sub_en    (sub_en),
    .fn_sel    (fn_sel),
    .result    (result),
    .zero      (zero),
    .carry_out (carry_out)
);

// File: tb/test_int_alu5.sv
// Bench: scoreboard for int_alu5. The driver task applies one vector per
// clock and queues its expected outputs; the monitor pops on the falling edge.
module test_int_alu5;

    localparam int  W      = 32;
    localparam time CLK_PER = 10ns;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         s;
        logic [1:0]   f;
        logic [W-1:0] exp_res;
        logic         exp_zero;
        logic         exp_cy;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         s_i = 1'b0;
    logic [1:0]   f_i = 2'b00;
    logic [W-1:0] res_o;
    logic         zero_o;
    logic         cy_o;

    item_t q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    int_alu5 #(.DATA_W(W)) i_int_alu5 (
        .opnd_a    (a_i),
        .opnd_b    (b_i),
        .sub_en    (s_i),
        .fn_sel    (f_i),
        .result    (res_o),
        .zero      (zero_o),
        .carry_out (cy_o)
    );

    always #(CLK_PER/2) clk = ~clk;

    // Driver: apply a vector at the rising edge and queue expected values.
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic s, input logic [1:0] f, input string tag);
        item_t it;
        logic [W:0] ext;
        @(posedge clk);
        a_i <= a; b_i <= b; s_i <= s; f_i <= f;
        ext = {1'b0, a} + {1'b0, (s ? ~b : b)} + {{W{1'b0}}, s};
        case (f)
            2'b00:   it.exp_res = a & b;
            2'b01:   it.exp_res = a | b;
            2'b10:   it.exp_res = ext[W-1:0];
            default: it.exp_res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
        endcase
        it.a = a; it.b = b; it.s = s; it.f = f; it.tag = tag;
        it.exp_zero = (it.exp_res == '0);
        it.exp_cy   = ext[W];
        q.push_back(it);
    endtask

    // Monitor: compare outputs at the falling edge against the queue head.
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if (res_o !== it.exp_res) begin
                n_fail++;
                $display("FAIL %s result a=%h b=%h s=%0b f=%b actual=%h expected=%h",
                         it.tag, it.a, it.b, it.s, it.f, res_o, it.exp_res);
            end
            n_chk++;
            if (zero_o !== it.exp_zero) begin
                n_fail++;
                $display("FAIL %s/R7 zero a=%h b=%h actual=%0b expected=%0b",
                         it.tag, it.a, it.b, zero_o, it.exp_zero);
            end
            if (it.f == 2'b10) begin
                n_chk++;
                if (cy_o !== it.exp_cy) begin
                    n_fail++;
                    $display("FAIL %s/R8 carry a=%h b=%h actual=%0b expected=%0b",
                             it.tag, it.a, it.b, cy_o, it.exp_cy);
                end
            end
        end
    end

    // Watchdog: a hung run ends as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Stimulus: reset-time check, directed corners, then sweeps.
    initial begin
        logic [W-1:0] ra, rb;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (res_o !== '0 || zero_o !== 1'b1) begin
            n_fail++;
            $display("FAIL R7 reset state actual=%h/%0b expected=0/1", res_o, zero_o);
        end
        rst_n = 1'b1;

        drive(32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 2'b00, "R1");
        drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 2'b00, "R1"); // AND to zero
        drive(32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 2'b01, "R2");
        drive(32'h0000_0000, 32'h0000_0000, 1'b0, 2'b01, "R2");
        drive(32'h1234_5678, 32'h1111_1111, 1'b0, 2'b10, "R3");
        drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 2'b10, "R9"); // wraps to 0, carry 1
        drive(32'hFFFF_FFFF, 32'h0000_0002, 1'b0, 2'b10, "R9"); // nonzero, carry 1
        drive(32'h0000_0005, 32'h0000_0005, 1'b1, 2'b10, "R4"); // equal: zero, carry 1
        drive(32'h0000_0003, 32'h0000_0005, 1'b1, 2'b10, "R4"); // borrow: carry 0
        drive(32'h8000_0000, 32'h0000_0001, 1'b1, 2'b10, "R4");
        drive(32'h0000_0003, 32'h0000_0007, 1'b1, 2'b11, "R5");
        drive(32'h0000_0007, 32'h0000_0003, 1'b1, 2'b11, "R5");
        drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 2'b11, "R5"); // -1 < 1
        drive(32'h0000_0009, 32'h0000_0009, 1'b1, 2'b11, "R5"); // equal gives 0
        drive(32'h8000_0000, 32'h0000_0001, 1'b1, 2'b11, "R6"); // overflowing diff
        drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 2'b11, "R6");
        drive(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 2'b11, "R6");
        drive(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 2'b11, "R6");

        for (int i = 0; i < W; i++) begin
            drive(32'h1 << i, 32'h1 << ((i + 5) % W), 1'b0, 2'b10, "R3");
            drive(32'h1 << i, 32'h1 << ((i + 5) % W), 1'b1, 2'b11, "R5");
        end
        for (int i = 0; i < 300; i++) begin
            ra = $urandom;
            rb = $urandom;
            drive(ra, rb, 1'b0, 2'b00, "R1");
            drive(ra, rb, 1'b0, 2'b01, "R2");
            drive(ra, rb, 1'b0, 2'b10, "R3");
            drive(ra, rb, 1'b1, 2'b10, "R4");
            drive(ra, rb, 1'b1, 2'b11, "R6");
            drive(ra, ra, 1'b1, 2'b10, "R4");
        end

        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule